// File: doc/BRIEF.md
# Packed SIMD Lane ALU

This block performs one packed operation on a 64-bit vector operand pair each cycle. The vector is treated as eight signed 8-bit lanes or four signed 16-bit lanes. A 5-bit selector code fixes the lane width and also chooses where the second operand comes from. The second operand can be one element of the second vector copied to every lane, the whole second vector lane for lane, or a 5-bit immediate copied to every lane. The operations are saturating arithmetic, wrapping subtract, bitwise logic, signed min/max, shifts, signed compares that set per-lane condition flags, and per-lane picks steered by those flags.

An operation is accepted when `in_valid` is high. The block is always ready. Its result, the condition flags and an illegal-encoding flag are registered, so they appear one cycle after the operation is accepted. A compare changes only the condition flags. Every other legal operation changes only the result vector. Lane 0 occupies the least-significant bits and lane numbers rise toward bit 63.

Top module: `simd_lane_alu`

## Requirements
- R1: Reset (synchronous, active high) clears `res_vec`, `cond_flags`, `out_valid` and `illegal_op` to zero, and `in_ready` is always 1.
- R2: An operation accepted at a clock edge raises `out_valid` for exactly the next cycle, with its effect visible in that same cycle; back-to-back operations are accepted one per cycle. Operation codes on `op_code`: 0 add, 1 subtract, 2 multiply, 3 and, 4 or, 5 xor, 6 nor, 7 min, 8 max, 9 compare-equal, 10 compare-less, 11 compare-less-or-equal, 12 pick-true, 13 pick-false, 14 shift-left, 15 logical shift-right, 16 arithmetic shift-right.
- R3: A `sel_code` whose bits [1:0] equal 11 (bits [2:0] = 011 or 111), or an `op_code` above 16, is illegal: `illegal_op` rises together with `out_valid`, and neither `res_vec` nor `cond_flags` changes.
- R4: `sel_code` bit 0 = 0 selects byte lanes and bits [1:0] = 01 selects halfword lanes. With bit 4 = 0 the second operand is element `sel_code[3:1]` (bytes) or `sel_code[3:2]` (halfwords) of `vec_b`, copied to all lanes. With bits [4:3] = 10 it is `vec_b` lane for lane. With bits [4:3] = 11 it is `imm_val`, zero-extended, in every lane.
- R5: Add saturates each lane to the signed range: 0x7F/0x80 for bytes, 0x7FFF/0x8000 for halfwords.
- R6: Multiply keeps the signed product per lane, saturated to the same limits as R5.
- R7: Subtract wraps modulo the lane width.
- R8: And, or, xor and nor act bitwise on the two operands.
- R9: Min and max compare the lanes as signed values.
- R10: The compares are signed and set `cond_flags[i]` for lane i. In halfword mode only bits [3:0] are written and bits [7:4] keep their values. Compares leave `res_vec` unchanged, and non-compare operations leave `cond_flags` unchanged.
- R11: Pick-true takes the `vec_a` lane where `cond_flags[i]` is 1 and the second operand otherwise. Pick-false does the opposite.
- R12: Shift counts are the low 3 bits (bytes) or low 4 bits (halfwords) of each lane of the second operand. Logical right shift fills with zeros and arithmetic right shift copies the sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_ready | output | 1 | Operation can be accepted (always 1) |
| op_code | input | 5 | Operation code |
| sel_code | input | 5 | Lane format and second-operand source |
| imm_val | input | 5 | Immediate used when the selector picks it |
| vec_a | input | 64 | First operand vector |
| vec_b | input | 64 | Second operand vector |
| out_valid | output | 1 | Registered result of an accepted operation |
| res_vec | output | 64 | Result vector register |
| cond_flags | output | 8 | Per-lane condition flags |
| illegal_op | output | 1 | Accepted operation had an illegal encoding |

## Verification
The hardest state to reach from the ports is a halfword compare that runs while the upper condition flags hold ones. A preceding all-equal byte compare sets all eight flags, so the halfword compare that follows must leave bits [7:4] visibly set. The pick operations then read a known mixed flag pattern. Illegal encodings are issued after this, so the checks can confirm that both the result and the nonzero flags stay unchanged.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

    localparam int OP_W  = 5;
    localparam int SEL_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_MUL   = 5'd2,
        OP_AND   = 5'd3,
        OP_OR    = 5'd4,
        OP_XOR   = 5'd5,
        OP_NOR   = 5'd6,
        OP_MIN   = 5'd7,
        OP_MAX   = 5'd8,
        OP_CEQ   = 5'd9,
        OP_CLT   = 5'd10,
        OP_CLE   = 5'd11,
        OP_PICKT = 5'd12,
        OP_PICKF = 5'd13,
        OP_SLL   = 5'd14,
        OP_SRL   = 5'd15,
        OP_SRA   = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        FMT_BYTE = 2'd0,
        FMT_HALF = 2'd1,
        FMT_BAD  = 2'd2
    } lane_fmt_e;

    typedef enum logic [1:0] {
        SRC_ELEM = 2'd0,
        SRC_VEC  = 2'd1,
        SRC_IMM  = 2'd2
    } opnd_src_e;

    typedef struct packed {
        lane_fmt_e fmt;
        opnd_src_e src;
        logic [2:0] idx;
        logic       is_cmp;
        logic       illegal;
    } sel_dec_t;

    function automatic logic op_is_compare(input logic [OP_W-1:0] op);
        return (op == OP_CEQ) || (op == OP_CLT) || (op == OP_CLE);
    endfunction

    function automatic logic op_is_known(input logic [OP_W-1:0] op);
        return op <= OP_SRA;
    endfunction

endpackage

// File: rtl/simd_sel_decode.sv
`timescale 1ns/1ps
module simd_sel_decode
    import simd_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic [OP_W-1:0]  op_i,
    output sel_dec_t         dec_o
);

    always_comb begin
        if (!sel_i[0]) begin
            dec_o.fmt = FMT_BYTE;
        end else if (!sel_i[1]) begin
            dec_o.fmt = FMT_HALF;
        end else begin
            dec_o.fmt = FMT_BAD;
        end

        if (!sel_i[4]) begin
            dec_o.src = SRC_ELEM;
        end else if (sel_i[3]) begin
            dec_o.src = SRC_IMM;
        end else begin
            dec_o.src = SRC_VEC;
        end

        dec_o.idx     = sel_i[3:1];
        dec_o.is_cmp  = op_is_compare(op_i);
        dec_o.illegal = (dec_o.fmt == FMT_BAD) || !op_is_known(op_i);
    end

endmodule

// File: rtl/simd_operand_mux.sv
`timescale 1ns/1ps
module simd_operand_mux
    import simd_pkg::*;
#(
    parameter int VEC_W = 64,
    parameter int IMM_W = 5
) (
    input  logic [VEC_W-1:0] vt_i,
    input  logic [IMM_W-1:0] imm_i,
    input  opnd_src_e        src_i,
    input  logic [2:0]       idx_i,
    output logic [VEC_W-1:0] b_byte_o,
    output logic [VEC_W-1:0] b_half_o
);

    localparam int NB = VEC_W / 8;
    localparam int NH = VEC_W / 16;

    logic [7:0]  elem_b;
    logic [15:0] elem_h;
    logic [7:0]  imm_b;
    logic [15:0] imm_h;

    always_comb begin
        elem_b = vt_i[idx_i*8 +: 8];
        elem_h = vt_i[idx_i[2:1]*16 +: 16];
        imm_b  = {{(8-IMM_W){1'b0}}, imm_i};
        imm_h  = {{(16-IMM_W){1'b0}}, imm_i};
    end

    for (genvar gb = 0; gb < NB; gb++) begin : g_byte
        always_comb begin
            unique case (src_i)
                SRC_ELEM: b_byte_o[gb*8 +: 8] = elem_b;
                SRC_IMM:  b_byte_o[gb*8 +: 8] = imm_b;
                default:  b_byte_o[gb*8 +: 8] = vt_i[gb*8 +: 8];
            endcase
        end
    end

    for (genvar gh = 0; gh < NH; gh++) begin : g_half
        always_comb begin
            unique case (src_i)
                SRC_ELEM: b_half_o[gh*16 +: 16] = elem_h;
                SRC_IMM:  b_half_o[gh*16 +: 16] = imm_h;
                default:  b_half_o[gh*16 +: 16] = vt_i[gh*16 +: 16];
            endcase
        end
    end

endmodule

// File: rtl/simd_lane_unit.sv
`timescale 1ns/1ps
module simd_lane_unit
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            pick_i,
    output logic [W-1:0]    res_o,
    output logic            flag_o
);

    localparam int SH_W = $clog2(W);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    alu_op_e               op_e;
    logic        [W:0]     sum_w;
    logic signed [2*W-1:0] a_ext;
    logic signed [2*W-1:0] b_ext;
    logic signed [2*W-1:0] prod_w;
    logic        [W:0]     prod_top;
    logic                  sum_ovf;
    logic                  prod_ovf;
    logic                  a_lt_b;
    logic [SH_W-1:0]       sh;

    always_comb begin
        op_e     = alu_op_e'(op_i);
        sum_w    = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        sum_ovf  = sum_w[W] ^ sum_w[W-1];
        a_ext    = {{W{a_i[W-1]}}, a_i};
        b_ext    = {{W{b_i[W-1]}}, b_i};
        prod_w   = a_ext * b_ext;
        prod_top = prod_w[2*W-1:W-1];
        prod_ovf = (prod_top != '0) && (prod_top != '1);
        a_lt_b   = $signed(a_i) < $signed(b_i);
        sh       = b_i[SH_W-1:0];

        flag_o = 1'b0;
        res_o  = a_i;
        case (op_e)
            OP_ADD:   res_o = sum_ovf ? (sum_w[W] ? S_MIN : S_MAX) : sum_w[W-1:0];
            OP_SUB:   res_o = a_i - b_i;
            OP_MUL:   res_o = prod_ovf ? (prod_w[2*W-1] ? S_MIN : S_MAX) : prod_w[W-1:0];
            OP_AND:   res_o = a_i & b_i;
            OP_OR:    res_o = a_i | b_i;
            OP_XOR:   res_o = a_i ^ b_i;
            OP_NOR:   res_o = ~(a_i | b_i);
            OP_MIN:   res_o = a_lt_b ? a_i : b_i;
            OP_MAX:   res_o = a_lt_b ? b_i : a_i;
            OP_CEQ:   flag_o = (a_i == b_i);
            OP_CLT:   flag_o = a_lt_b;
            OP_CLE:   flag_o = a_lt_b || (a_i == b_i);
            OP_PICKT: res_o = pick_i ? a_i : b_i;
            OP_PICKF: res_o = pick_i ? b_i : a_i;
            OP_SLL:   res_o = a_i << sh;
            OP_SRL:   res_o = a_i >> sh;
            OP_SRA:   res_o = $signed(a_i) >>> sh;
            default:  res_o = a_i;
        endcase
    end

endmodule

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu
    import simd_pkg::*;
#(
    parameter int VEC_W = 64,
    parameter int IMM_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [OP_W-1:0]      op_code,
    input  logic [SEL_W-1:0]     sel_code,
    input  logic [IMM_W-1:0]     imm_val,
    input  logic [VEC_W-1:0]     vec_a,
    input  logic [VEC_W-1:0]     vec_b,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     res_vec,
    output logic [VEC_W/8-1:0]   cond_flags,
    output logic                 illegal_op
);

    localparam int NB = VEC_W / 8;
    localparam int NH = VEC_W / 16;

    sel_dec_t         dec;
    logic [VEC_W-1:0] b_byte;
    logic [VEC_W-1:0] b_half;
    logic [VEC_W-1:0] res_byte;
    logic [VEC_W-1:0] res_half;
    logic [NB-1:0]    flag_byte;
    logic [NH-1:0]    flag_half;
    logic             accept;

    logic [VEC_W-1:0] result_q;
    logic [NB-1:0]    cond_q;
    logic             valid_q;
    logic             illegal_q;

    assign in_ready = 1'b1;
    assign accept   = in_valid && in_ready;

    simd_sel_decode u_dec (
        .sel_i (sel_code),
        .op_i  (op_code),
        .dec_o (dec)
    );

    simd_operand_mux #(
        .VEC_W (VEC_W),
        .IMM_W (IMM_W)
    ) u_mux (
        .vt_i     (vec_b),
        .imm_i    (imm_val),
        .src_i    (dec.src),
        .idx_i    (dec.idx),
        .b_byte_o (b_byte),
        .b_half_o (b_half)
    );

    for (genvar gb = 0; gb < NB; gb++) begin : g_byte_lane
        simd_lane_unit #(.W(8)) u_lane (
            .op_i   (op_code),
            .a_i    (vec_a[gb*8 +: 8]),
            .b_i    (b_byte[gb*8 +: 8]),
            .pick_i (cond_q[gb]),
            .res_o  (res_byte[gb*8 +: 8]),
            .flag_o (flag_byte[gb])
        );
    end

    for (genvar gh = 0; gh < NH; gh++) begin : g_half_lane
        simd_lane_unit #(.W(16)) u_lane (
            .op_i   (op_code),
            .a_i    (vec_a[gh*16 +: 16]),
            .b_i    (b_half[gh*16 +: 16]),
            .pick_i (cond_q[gh]),
            .res_o  (res_half[gh*16 +: 16]),
            .flag_o (flag_half[gh])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q  <= '0;
            cond_q    <= '0;
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            valid_q   <= accept;
            illegal_q <= accept && dec.illegal;
            if (accept && !dec.illegal) begin
                if (dec.is_cmp) begin
                    if (dec.fmt == FMT_BYTE) begin
                        cond_q <= flag_byte;
                    end else begin
                        cond_q[NH-1:0] <= flag_half;
                    end
                end else begin
                    result_q <= (dec.fmt == FMT_BYTE) ? res_byte : res_half;
                end
            end
        end
    end

    assign out_valid  = valid_q;
    assign res_vec    = result_q;
    assign cond_flags = cond_q;
    assign illegal_op = illegal_q;

endmodule

// File: rtl/simd_lane_alu_checker.sv
`timescale 1ns/1ps
module simd_lane_alu_checker #(
    parameter int VEC_W = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [4:0]         op_code,
    input logic [4:0]         sel_code,
    input logic               out_valid,
    input logic [VEC_W-1:0]   res_vec,
    input logic [VEC_W/8-1:0] cond_flags,
    input logic               illegal_op
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            a_r1_reset_clears: assert (!out_valid && !illegal_op && res_vec == '0 && cond_flags == '0)
                else $error("R1: state not cleared after reset");
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_illegal_with_valid: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> out_valid);

    a_r3_illegal_no_update: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal_op) |-> ($stable(res_vec) && $stable(cond_flags)));

    a_r10_half_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel_code[0]) |=> $stable(cond_flags[VEC_W/8-1:4]));

    a_r10_compare_keeps_result: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_code == 5'd9 || op_code == 5'd10 || op_code == 5'd11)) |=> $stable(res_vec));

endmodule

bind simd_lane_alu simd_lane_alu_checker #(.VEC_W(VEC_W)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .sel_code   (sel_code),
    .out_valid  (out_valid),
    .res_vec    (res_vec),
    .cond_flags (cond_flags),
    .illegal_op (illegal_op)
);

// File: tb/simd_lane_alu_bench.sv
`timescale 1ns/1ps
module simd_lane_alu_bench;

    localparam logic [4:0] C_ADD = 5'd0,  C_SUB = 5'd1,  C_MUL = 5'd2,  C_AND = 5'd3;
    localparam logic [4:0] C_OR  = 5'd4,  C_XOR = 5'd5,  C_NOR = 5'd6,  C_MIN = 5'd7;
    localparam logic [4:0] C_MAX = 5'd8,  C_CEQ = 5'd9,  C_CLT = 5'd10, C_CLE = 5'd11;
    localparam logic [4:0] C_PKT = 5'd12, C_PKF = 5'd13, C_SLL = 5'd14, C_SRL = 5'd15;
    localparam logic [4:0] C_SRA = 5'd16;

    localparam logic [4:0] S_BVEC = 5'b10000, S_HVEC = 5'b10001;
    localparam logic [4:0] S_BIMM = 5'b11000, S_HIMM = 5'b11001;

    typedef struct packed {
        logic [4:0]  op;
        logic [4:0]  sel;
        logic [4:0]  imm;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{C_ADD, S_BVEC, 5'd0, 64'h01020304_7F8010F0, 64'h01010101_01FF20F0, 64'h02030405_7F8030E0, 8'd5},  // R5
        '{C_SUB, S_BVEC, 5'd0, 64'h01020304_7F8010F0, 64'h01010101_01FF20F0, 64'h00010203_7E81F000, 8'd7},  // R7
        '{C_ADD, S_HVEC, 5'd0, 64'h7FFF8000_1234FFFF, 64'h0001FFFF_11110001, 64'h7FFF8000_23450000, 8'd5},  // R5
        '{C_MUL, S_BVEC, 5'd0, 64'h10F07F80_03FD0200, 64'h10100202_0404FF55, 64'h7F807F80_0CF4FE00, 8'd6},  // R6
        '{C_MUL, 5'b01001, 5'd0, 64'h0080FF80_00010000, 64'h00030100_FFFE0000, 64'h7FFF8000_01000000, 8'd6}, // R6, R4
        '{C_AND, 5'b01010, 5'd0, 64'h01234567_89ABCDEF, 64'h0000F000_00000000, 64'h00204060_80A0C0E0, 8'd4}, // R4, R8
        '{C_OR,  S_BIMM, 5'h11, 64'h00000000_FFFF0F0F, 64'h0, 64'h11111111_FFFF1F1F, 8'd4},                 // R4, R8
        '{C_XOR, S_HVEC, 5'd0, 64'hFFFF0000_AAAA1234, 64'h0F0FFFFF_55551234, 64'hF0F0FFFF_FFFF0000, 8'd8},  // R8
        '{C_NOR, S_BVEC, 5'd0, 64'h00FF0F00_00000000, 64'h0000F000_00000001, 64'hFF0000FF_FFFFFFFE, 8'd8},  // R8
        '{C_MIN, S_BVEC, 5'd0, 64'h807F01FF_00000000, 64'h7F80FF01_00000000, 64'h8080FFFF_00000000, 8'd9},  // R9
        '{C_MAX, S_HVEC, 5'd0, 64'h80007FFF_0001FFFF, 64'h7FFF8000_FFFF0000, 64'h7FFF7FFF_00010000, 8'd9},  // R9
        '{C_SLL, S_BIMM, 5'h0B, 64'h01020408_102040FF, 64'h0, 64'h08102040_800000F8, 8'd12},               // R12
        '{C_SRL, S_HIMM, 5'h14, 64'h8000FFFF_123400F0, 64'h0, 64'h08000FFF_0123000F, 8'd12},               // R12
        '{C_SRA, S_HVEC, 5'd0, 64'h8000FFFF_12347FFF, 64'h000F0004_00110001, 64'hFFFFFFFF_091A3FFF, 8'd12}, // R12
        '{C_SRA, S_BVEC, 5'd0, 64'h8040F001_00000000, 64'h070A0400_00000000, 64'hFF10FF01_00000000, 8'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [4:0]  op_code;
    logic [4:0]  sel_code;
    logic [4:0]  imm_val;
    logic [63:0] vec_a;
    logic [63:0] vec_b;
    logic        out_valid;
    logic [63:0] res_vec;
    logic [7:0]  cond_flags;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    simd_lane_alu u_simd_lane_alu (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .op_code    (op_code),
        .sel_code   (sel_code),
        .imm_val    (imm_val),
        .vec_a      (vec_a),
        .vec_b      (vec_b),
        .out_valid  (out_valid),
        .res_vec    (res_vec),
        .cond_flags (cond_flags),
        .illegal_op (illegal_op)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [4:0] sel, input logic [4:0] imm,
                         input logic [63:0] a, input logic [63:0] b);
        op_code  = op;
        sel_code = sel;
        imm_val  = imm;
        vec_a    = a;
        vec_b    = b;
        in_valid = 1'b1;
    endtask

    task automatic run_op(input logic [4:0] op, input logic [4:0] sel, input logic [4:0] imm,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        drive(op, sel, imm, a, b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        op_code = '0;
        sel_code = '0;
        imm_val = '0;
        vec_a = '0;
        vec_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 result", res_vec, 64'h0);
        chk("R1 cond", {56'h0, cond_flags}, 64'h0);
        chk("R1 valid", {63'h0, out_valid}, 64'h0);
        chk("R1 illegal", {63'h0, illegal_op}, 64'h0);
        chk("R1 ready", {63'h0, in_ready}, 64'h1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].op, VECS[i].sel, VECS[i].imm, VECS[i].a, VECS[i].b);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), res_vec, VECS[i].exp);
            chk("R2 valid after op", {63'h0, out_valid}, 64'h1);
        end
        @(negedge clk);
        chk("R2 valid drops when idle", {63'h0, out_valid}, 64'h0);

        // R10 compares (byte), result must stay at last table value
        run_op(C_CLT, S_BVEC, 5'd0, 64'h800105000_0FF7F00 >> 0, 64'h0);
        run_op(C_CLT, S_BVEC, 5'd0, 64'h80010500_00FF7F00, 64'h00010400_01008000);
        chk("R10 less-than flags", {56'h0, cond_flags}, 64'h8C);
        chk("R10 compare keeps result", res_vec, 64'hFF10FF01_00000000);
        run_op(C_CLE, S_BVEC, 5'd0, 64'h80010500_00FF7F00, 64'h00010400_01008000);
        chk("R10 less-or-equal flags", {56'h0, cond_flags}, 64'hDD);
        run_op(C_CEQ, S_BVEC, 5'd0, 64'h12345678_9ABCDEF0, 64'h12345678_9ABCDEF0);
        chk("R10 equal all lanes", {56'h0, cond_flags}, 64'hFF);
        run_op(C_CEQ, S_HVEC, 5'd0, 64'h00010002_00030004, 64'h00010000_00030000);
        chk("R10 halfword keeps upper flags", {56'h0, cond_flags}, 64'hFA);

        // R10 non-compare leaves flags
        run_op(C_ADD, S_BIMM, 5'd1, 64'h0, 64'h0);
        chk("R4 immediate add", res_vec, 64'h01010101_01010101);
        chk("R10 non-compare keeps flags", {56'h0, cond_flags}, 64'hFA);

        // R11 picks with flags 0xFA
        run_op(C_PKT, S_BVEC, 5'd0, 64'h11111111_11111111, 64'h22222222_22222222);
        chk("R11 pick-true bytes", res_vec, 64'h11111111_11221122);
        run_op(C_PKF, S_BVEC, 5'd0, 64'h11111111_11111111, 64'h22222222_22222222);
        chk("R11 pick-false bytes", res_vec, 64'h22222222_22112211);
        run_op(C_PKT, S_HVEC, 5'd0, 64'hAAAABBBB_CCCCDDDD, 64'h11112222_33334444);
        chk("R11 pick-true halfwords", res_vec, 64'hAAAA2222_CCCC4444);

        // R3 illegal encodings
        run_op(C_ADD, 5'b10011, 5'd0, 64'h1, 64'h1);
        chk("R3 illegal flag (011)", {63'h0, illegal_op}, 64'h1);
        chk("R3 valid with illegal", {63'h0, out_valid}, 64'h1);
        chk("R3 result kept", res_vec, 64'hAAAA2222_CCCC4444);
        run_op(C_CEQ, 5'b00111, 5'd0, 64'h0, 64'h5);
        chk("R3 illegal flag (111)", {63'h0, illegal_op}, 64'h1);
        chk("R3 flags kept", {56'h0, cond_flags}, 64'hFA);
        run_op(5'd17, S_BVEC, 5'd0, 64'h3, 64'h3);
        chk("R3 undefined op", {63'h0, illegal_op}, 64'h1);
        chk("R3 undefined op result kept", res_vec, 64'hAAAA2222_CCCC4444);

        // R4 element broadcast boundaries
        run_op(C_ADD, 5'b01110, 5'd0, 64'h0, 64'h05000000_00000000);
        chk("R4 byte element 7", res_vec, 64'h05050505_05050505);
        chk("R3 legal clears flag", {63'h0, illegal_op}, 64'h0);
        run_op(C_ADD, 5'b00001, 5'd0, 64'h0, 64'h12345678_9ABC0007);
        chk("R4 halfword element 0", res_vec, 64'h00070007_00070007);

        // R2 back-to-back operations
        @(negedge clk);
        drive(C_ADD, S_BIMM, 5'd2, 64'h0, 64'h0);
        @(negedge clk);
        drive(C_SUB, S_BVEC, 5'd0, 64'h0, 64'h01010101_01010101);
        chk("R2 first of pair", res_vec, 64'h02020202_02020202);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 second of pair", res_vec, 64'hFFFFFFFF_FFFFFFFF);
        chk("R2 valid on second", {63'h0, out_valid}, 64'h1);

        // R1 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 result cleared", res_vec, 64'h0);
        chk("R1 flags cleared", {56'h0, cond_flags}, 64'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule